// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

This block turns bytes into asynchronous serial frames on a single output line. Each serial bit is stretched over a fixed number of pulses of an external baud tick. The baud tick comes from a rate generator outside the block, so the block itself never divides the clock. A frame starts with a low start bit. The data bits follow, least significant first. After them comes an optional extra bit and then one or two high stop bits. The extra bit is either a computed parity bit, with even or odd sense, or a caller-supplied ninth bit used to mark address bytes in multi-drop links.

Bytes are offered with a valid/ready handshake. Data, ninth bit and frame configuration are all captured in the cycle a byte is accepted, so the host may change the configuration inputs while a frame is on the line.

The break control overrides everything else. While break is high, the line is low in the same cycle. Any frame being sent is thrown away and the transmitter returns to idle. When break is released, the line goes straight back to high with no stop bit, and the host is left to time any gap it wants.

Top module: `uart_brk_tx`

## Requirements
- R1: Out of reset, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame begins with a start bit of 0, followed by the 8 data bits, bit 0 first.
- R3: Every serial bit stays on the line for exactly 16 cycles in which `baud_tick` is 1. Cycles without a tick never advance the frame.
- R4: With `cfg_par_en`=1 and `cfg_nine_bit`=0, a parity bit follows data bit 7. Its value is the XOR of the data bits when `cfg_par_odd`=0 (even sense) and the inverted XOR when `cfg_par_odd`=1 (odd sense).
- R5: With `cfg_nine_bit`=1, the bit after data bit 7 is `mp_bit`, whatever `cfg_par_en` and `cfg_par_odd` are.
- R6: With `cfg_par_en`=0 and `cfg_nine_bit`=0, no bit is inserted between data bit 7 and the first stop bit.
- R7: The frame ends with one stop bit of 1 when `cfg_two_stop`=0 and with two when `cfg_two_stop`=1.
- R8: `in_ready` is 1 only when the transmitter is idle and `cfg_brk` is 0. A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. `busy` stays 1 from the next cycle until the last stop bit has ended. Data, `mp_bit` and configuration are sampled at acceptance.
- R9: While `cfg_brk` is 1, `tx_line` is 0 in the same cycle, whether the transmitter is idle or sending.
- R10: Raising `cfg_brk` during a frame abandons the frame: `busy` is 0 from the next cycle, and `in_valid` has no effect while break is high.
- R11: When `cfg_brk` falls, `tx_line` is 1 in the same cycle and stays 1, with no stop bit or leftover frame sent. The next accepted byte starts a fresh frame with its start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle baud enable pulse |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be accepted this cycle |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_nine_bit | input | 1 | Send mp_bit in the extra-bit slot |
| cfg_brk | input | 1 | Force line low and abort any frame |
| mp_bit | input | 1 | Ninth bit for multi-drop addressing |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that every input is synchronous to `clk` and known after reset. They also assume that `baud_tick` is a level sampled once per edge, not a multi-cycle strobe that the block should treat as a single tick. The bench changes inputs only a quarter period after a rising edge and samples outputs just before the next input change.

The bench sweeps every combination of the four frame settings and the ninth bit over eight data bytes, including all-zeros and all-ones. Some frames insert idle cycles between ticks. In every frame the configuration inputs are inverted right after acceptance.

Break is raised both when idle and in mid-frame, with `in_valid` held high during the break. `in_valid` is always dropped a cycle before break is released, so that the expected first accepted byte is unambiguous.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
    logic nine_bit;
  } frame_cfg_t;

endpackage

// File: rtl/uart_brk_tx_tick_div.sv
module uart_brk_tx_tick_div #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic baud_tick,
  output logic bit_end
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && baud_tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign bit_end = run && baud_tick && (cnt_q == LAST);

  // R3: the counter never moves while the transmitter is idle
  a_r3_idle_counter_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_brk_tx_frame.sv
module uart_brk_tx_frame
  import uart_brk_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic              advance,
  input  logic [DATA_W-1:0] data,
  input  frame_cfg_t        cfg,
  input  logic              mp,
  output logic              line_bit,
  output logic              last_bit
);
  localparam int FRAME_MAX = DATA_W + 4;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);

  function automatic logic has_extra(input frame_cfg_t c);
    return c.par_en || c.nine_bit;
  endfunction

  function automatic logic extra_value(input logic [DATA_W-1:0] d,
                                       input frame_cfg_t c, input logic m);
    return c.nine_bit ? m : ((^d) ^ c.par_odd);
  endfunction

  function automatic logic [IDX_W-1:0] frame_len(input frame_cfg_t c);
    logic [IDX_W-1:0] n;
    n = IDX_W'(DATA_W + 2);
    if (has_extra(c)) n = n + IDX_W'(1);
    if (c.two_stop)   n = n + IDX_W'(1);
    return n;
  endfunction

  function automatic logic [FRAME_MAX-1:0] frame_bits(input logic [DATA_W-1:0] d,
                                                      input frame_cfg_t c,
                                                      input logic m);
    logic [FRAME_MAX-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = d;
    if (has_extra(c)) f[DATA_W+1] = extra_value(d, c, m);
    return f;
  endfunction

  logic [FRAME_MAX-1:0] sreg_q;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '1;
      idx_q  <= '0;
      len_q  <= IDX_W'(1);
    end else if (clear) begin
      sreg_q <= '1;
      idx_q  <= '0;
    end else if (load) begin
      sreg_q <= frame_bits(data, cfg, mp);
      idx_q  <= '0;
      len_q  <= frame_len(cfg);
    end else if (advance) begin
      sreg_q <= {1'b1, sreg_q[FRAME_MAX-1:1]};
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign line_bit = sreg_q[0];
  assign last_bit = (idx_q == len_q - IDX_W'(1));

  // R7: the bit index never runs past the frame length
  a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < len_q);

  // R3: without a bit boundary the frame state holds
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load && !clear) |=> ($stable(idx_q) && $stable(sreg_q)));

endmodule

// File: rtl/uart_brk_tx_ctrl.sv
module uart_brk_tx_ctrl
  import uart_brk_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic cfg_brk,
  input  logic bit_end,
  input  logic last_bit,
  output logic in_ready,
  output logic busy,
  output logic load,
  output logic clear
);
  tx_state_e state_q;
  logic      finish;
  logic      abort;

  assign busy     = (state_q == ST_SEND);
  assign in_ready = (state_q == ST_IDLE) && !cfg_brk;
  assign load     = in_valid && in_ready;
  assign abort    = busy && cfg_brk;
  assign finish   = busy && !cfg_brk && bit_end && last_bit;
  assign clear    = abort || finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (load) begin
      state_q <= ST_SEND;
    end else if (clear) begin
      state_q <= ST_IDLE;
    end
  end

  // R10: break always leaves the transmitter idle one cycle later
  a_r10_break_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_brk |=> !busy);

  // R8: busy only drops at the last bit boundary or on break
  a_r8_busy_ends_cleanly: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end && !cfg_brk) |=> busy);

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_nine_bit,
  input  logic              cfg_brk,
  input  logic              mp_bit,
  output logic              tx_line,
  output logic              busy
);
  frame_cfg_t cfg_now;
  logic       bit_end;
  logic       last_bit;
  logic       load;
  logic       clear;
  logic       line_bit;

  assign cfg_now = '{par_en: cfg_par_en, par_odd: cfg_par_odd,
                     two_stop: cfg_two_stop, nine_bit: cfg_nine_bit};

  uart_brk_tx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cfg_brk  (cfg_brk),
    .bit_end  (bit_end),
    .last_bit (last_bit),
    .in_ready (in_ready),
    .busy     (busy),
    .load     (load),
    .clear    (clear)
  );

  uart_brk_tx_tick_div #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .restart   (load || clear),
    .baud_tick (baud_tick),
    .bit_end   (bit_end)
  );

  uart_brk_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .clear    (clear),
    .advance  (bit_end),
    .data     (in_data),
    .cfg      (cfg_now),
    .mp       (mp_bit),
    .line_bit (line_bit),
    .last_bit (last_bit)
  );

  assign tx_line = cfg_brk ? 1'b0 : line_bit;

  // R1: an idle, unbroken line rests high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_brk) |-> tx_line);

  // R2: an accepted byte opens with a low start bit
  a_r2_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && (cfg_brk || !tx_line)));

endmodule

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       cfg_nine_bit = 1'b0, cfg_brk = 1'b0, mp_bit = 1'b0;
  logic       in_ready, tx_line, busy;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  uart_brk_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_nine_bit(cfg_nine_bit), .cfg_brk(cfg_brk), .mp_bit(mp_bit),
    .tx_line(tx_line), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int exp_len(input bit pe, input bit nb, input bit ts);
    return 10 + ((pe || nb) ? 1 : 0) + (ts ? 1 : 0);
  endfunction

  function automatic bit exp_bit(input int k, input logic [7:0] d, input bit pe,
                                 input bit po, input bit nb, input bit mp);
    int ones;
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9 && nb) return mp;
    if (k == 9 && pe) begin
      ones = $countones(d);
      return po ? ((ones % 2) == 0) : ((ones % 2) == 1);
    end
    return 1'b1;
  endfunction

  function automatic string tag_of(input int k, input bit pe, input bit nb);
    if (k <= 8) return "R2 frame bit";
    if (k == 9 && nb) return "R5 ninth bit";
    if (k == 9 && pe) return "R4 parity bit";
    if (k == 9) return "R6 stop follows data";
    return "R7 stop bit";
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit pe, input bit po,
                            input bit ts, input bit nb, input bit mp, input int gap);
    int len;
    int hold_err;
    bit e;
    len = exp_len(pe, nb, ts);
    hold_err = 0;
    in_data = d; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    cfg_nine_bit = nb; mp_bit = mp; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    // R8: configuration changes after acceptance must not matter
    in_data = ~d; cfg_par_en = ~pe; cfg_par_odd = ~po; cfg_two_stop = ~ts;
    cfg_nine_bit = ~nb; mp_bit = ~mp;
    chk("R8 busy after accept", int'(busy), 1);
    chk("R8 ready low while busy", int'(in_ready), 0);
    for (int k = 0; k < len; k++) begin
      e = exp_bit(k, d, pe, po, nb, mp);
      chk(tag_of(k, pe, nb), int'(tx_line), int'(e));
      for (int t = 0; t < 16; t++) begin
        for (int g = 0; g < gap; g++) begin
          baud_tick = 1'b0;
          step();
          if (tx_line !== e) hold_err++;
        end
        baud_tick = 1'b1;
        step();
        baud_tick = 1'b0;
        if (t < 15 && tx_line !== e) hold_err++;
      end
    end
    chk("R3 bit held for 16 ticks", hold_err, 0);
    chk("R8 idle after last stop", int'(busy), 0);
    chk("R8 ready after frame", int'(in_ready), 1);
    chk("R7 line high after stop", int'(tx_line), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset line", int'(tx_line), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset ready", int'(in_ready), 1);

    for (int c = 0; c < 32; c++) begin
      for (int di = 0; di < 8; di++) begin
        d = (di == 0) ? 8'h00 : (di == 7) ? 8'hFF : 8'(di * 53 + c * 29);
        send_frame(d, c[0], c[1], c[2], c[3], c[4], (di % 3 == 0) ? 1 : 0);
      end
    end

    // R9: break while idle pulls the line low at once
    cfg_brk = 1'b1;
    #1;
    chk("R9 idle break low", int'(tx_line), 0);
    chk("R8 ready low in break", int'(in_ready), 0);
    step();
    cfg_brk = 1'b0;
    #1;
    chk("R11 release high", int'(tx_line), 1);
    step();

    // mid-frame break
    in_data = 8'hFF; cfg_par_en = 1'b0; cfg_nine_bit = 1'b0; cfg_two_stop = 1'b0;
    in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    for (int t = 0; t < 3 * 16 + 5; t++) begin
      baud_tick = 1'b1;
      step();
    end
    baud_tick = 1'b0;
    chk("R2 data bit before break", int'(tx_line), 1);
    cfg_brk = 1'b1;
    #1;
    chk("R9 break low mid-frame", int'(tx_line), 0);
    step();
    chk("R10 busy dropped", int'(busy), 0);
    chk("R10 ready low in break", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'h5A;
    for (int t = 0; t < 5; t++) begin
      baud_tick = 1'b1;
      step();
      chk("R10 valid ignored in break", int'(busy), 0);
      chk("R9 line low in break", int'(tx_line), 0);
    end
    baud_tick = 1'b0;
    in_valid = 1'b0;
    step();
    cfg_brk = 1'b0;
    #1;
    chk("R11 line high on release", int'(tx_line), 1);
    begin
      int bad;
      bad = 0;
      for (int t = 0; t < 40; t++) begin
        baud_tick = 1'b1;
        step();
        if (tx_line !== 1'b1 || busy !== 1'b0) bad++;
      end
      baud_tick = 1'b0;
      chk("R11 no stop or leftover frame", bad, 0);
    end
    send_frame(8'hA5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule